// File: doc/BRIEF.md
# Memory Attribute Resolver with Streaming Store Detection

This block turns the page-table attributes of a memory access (memory type, shareability and cache policy) into the treatment the level-one data cache actually applies. There are four outcomes: bypass the cache entirely, non-cacheable, write-back with allocation on write misses, or write-back without allocation. A separate output flags whether the access is treated as inner-shareable. A multiprocessor enable input decides whether shared write-back regions are kept cacheable.

The block also tracks full cache-line writes. When the same core writes whole lines at consecutive line addresses, a saturating run counter grows. While the run is longer than three lines, non-shareable write-back write-allocate regions are downgraded to no-write-allocate, so streaming stores do not evict useful data. Any read, partial write or break in the address sequence ends the run, and allocation is restored at once.

The attribute mapping is combinational. It is captured in one output register stage, so a result appears one cycle after its access. The run counter and the last line address are the only other state.

Top module: `mattr_resolver`

## Requirements
- R1: An access with memory type 0 (strongly ordered), 1 (device) or 3 (treated as device) resolves to kind 0 (bypass) with shared flag 0, whatever its shareability, cache policy and the multiprocessor enable.
- R2: A normal access (type 2) with shareability 0 (non-shareable) and cache policy 0 (non-cacheable) or 1 (write-through) resolves to kind 1 (non-cacheable) with shared flag 0.
- R3: A normal non-shareable access with cache policy 3 (write-back, no write-allocate) resolves to kind 2 (write-back, write-allocate) with shared flag 0.
- R4: A normal non-shareable access with cache policy 2 (write-back, write-allocate) resolves to kind 2 when no streaming run is active, and to kind 3 (write-back, no write-allocate) while one is active.
- R5: A full-line write whose line address is the previous full-line address plus one extends the run counter by one. A full-line write while the counter is 0, or at any other address, starts a new run at 1. A run is active while the counter is above THRESH (default 3), so it becomes active on the fourth consecutive line.
- R6: A partial-line write or a read sets the run counter to 0 on the same edge, with reads taking priority over writes in the same cycle. Write-allocate therefore returns for the next access.
- R7: The run counter saturates at 2**CNT_W-1 and never wraps to 0 while a sequential run continues.
- R8: A normal access with shareability 1 (inner) or 2/3 (outer) and cache policy 0 or 1 resolves to kind 1 with shared flag 1.
- R9: A normal shared access with cache policy 2 or 3 resolves to kind 1 with shared flag 1 when the multiprocessor enable is 0, and to kind 2 with shared flag 1 when it is 1.
- R10: Results are registered: res_valid is high exactly one cycle after acc_valid, and res_kind and res_shared hold their values in cycles without an access. After reset res_valid is 0, res_kind is 0 and res_shared is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access attributes present this cycle |
| acc_mtype | input | 2 | Memory type: 0 strongly ordered, 1 device, 2 normal, 3 device |
| acc_share | input | 2 | Shareability: 0 non, 1 inner, 2/3 outer |
| acc_cpol | input | 2 | Cache policy: 0 NC, 1 WT, 2 WB-WA, 3 WB-NWA |
| smp_en | input | 1 | Multiprocessor enable for shared write-back regions |
| wr_valid | input | 1 | A store is observed this cycle |
| wr_full | input | 1 | The observed store covers a whole cache line |
| wr_line | input | LINE_AW | Line address of the observed store |
| rd_valid | input | 1 | A load is observed this cycle |
| res_valid | output | 1 | Resolved result valid |
| res_kind | output | 2 | 0 bypass, 1 non-cacheable, 2 WB-WA, 3 WB-NWA |
| res_shared | output | 1 | Access treated as inner-shareable |

## Verification
Each resolution is due on the first rising edge after its access is presented. The bench drives inputs on the falling edge, releases them on the next falling edge and reads the outputs there, half a cycle after the capturing edge. Store and load events change the run counter on the edge where they are presented. So the access that probes the effect of a run is driven on the falling edge after the last store, and its result is read one full cycle later. The hold behaviour is checked on the cycle after a result, with acc_valid low.

// File: rtl/mattr_pkg.sv
package mattr_pkg;

  typedef enum logic [1:0] {
    MT_STRICT = 2'd0,
    MT_DEVICE = 2'd1,
    MT_NORMAL = 2'd2,
    MT_DEV_ALT = 2'd3
  } mtype_e;

  typedef enum logic [1:0] {
    SH_NONE  = 2'd0,
    SH_INNER = 2'd1,
    SH_OUTER = 2'd2,
    SH_OUT_ALT = 2'd3
  } share_e;

  typedef enum logic [1:0] {
    CP_NC    = 2'd0,
    CP_WT    = 2'd1,
    CP_WB_WA = 2'd2,
    CP_WB_NA = 2'd3
  } cpol_e;

  typedef enum logic [1:0] {
    RK_BYPASS = 2'd0,
    RK_NONC   = 2'd1,
    RK_WB_WA  = 2'd2,
    RK_WB_NA  = 2'd3
  } rkind_e;

  typedef struct packed {
    rkind_e kind;
    logic   shared;
  } resolved_t;

endpackage

// File: rtl/mattr_decode.sv
module mattr_decode
  import mattr_pkg::*;
(
  input  logic [1:0] mtype_i,
  input  logic [1:0] share_i,
  input  logic [1:0] cpol_i,
  input  logic       smp_en_i,
  input  logic       streaming_i,
  output resolved_t  res_o
);

  logic is_normal;
  logic is_shared;
  logic is_wb;

  assign is_normal = (mtype_i == MT_NORMAL);
  assign is_shared = (share_i != SH_NONE);
  assign is_wb     = (cpol_i == CP_WB_WA) || (cpol_i == CP_WB_NA);

  always_comb begin
    res_o.kind   = RK_BYPASS;
    res_o.shared = 1'b0;
    if (is_normal) begin
      if (!is_shared) begin
        unique case (cpol_i)
          CP_NC,
          CP_WT:    res_o.kind = RK_NONC;
          CP_WB_WA: res_o.kind = streaming_i ? RK_WB_NA : RK_WB_WA;
          CP_WB_NA: res_o.kind = RK_WB_WA;
          default:  res_o.kind = RK_NONC;
        endcase
      end else begin
        res_o.shared = 1'b1;
        if (is_wb && smp_en_i) begin
          res_o.kind = RK_WB_WA;
        end else begin
          res_o.kind = RK_NONC;
        end
      end
    end
  end

endmodule

// File: rtl/mattr_stream_det.sv
module mattr_stream_det #(
  parameter int LINE_AW = 26,
  parameter int CNT_W   = 3,
  parameter int THRESH  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid_i,
  input  logic               wr_full_i,
  input  logic [LINE_AW-1:0] wr_line_i,
  input  logic               rd_valid_i,
  output logic               streaming_o,
  output logic [CNT_W-1:0]   run_cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_THR = CNT_W'(THRESH);

  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [LINE_AW-1:0] last_q, last_d;
  logic               cnt_en;
  logic               seq_hit;

  assign seq_hit = (cnt_q != '0) && (wr_line_i == LINE_AW'(last_q + 1'b1));
  assign cnt_en  = rd_valid_i || wr_valid_i;

  always_comb begin
    cnt_d  = cnt_q;
    last_d = last_q;
    if (rd_valid_i) begin
      cnt_d = '0;
    end else if (wr_valid_i) begin
      if (!wr_full_i) begin
        cnt_d = '0;
      end else begin
        last_d = wr_line_i;
        if (seq_hit) begin
          cnt_d = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
        end else begin
          cnt_d = CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      last_q <= '0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      last_q <= last_d;
    end
  end

  assign streaming_o = (cnt_q > CNT_THR);
  assign run_cnt_o   = cnt_q;

endmodule

// File: rtl/mattr_out_reg.sv
module mattr_out_reg
  import mattr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      valid_i,
  input  resolved_t res_i,
  output logic      valid_o,
  output resolved_t res_o
);

  resolved_t res_q;
  logic      valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q.kind   <= RK_BYPASS;
      res_q.shared <= 1'b0;
    end else if (valid_i) begin
      res_q <= res_i;
    end
  end

  assign valid_o = valid_q;
  assign res_o   = res_q;

endmodule

// File: rtl/mattr_resolver.sv
module mattr_resolver
  import mattr_pkg::*;
#(
  parameter int LINE_AW = 26,
  parameter int CNT_W   = 3,
  parameter int THRESH  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  logic [1:0]         acc_mtype,
  input  logic [1:0]         acc_share,
  input  logic [1:0]         acc_cpol,
  input  logic               smp_en,
  input  logic               wr_valid,
  input  logic               wr_full,
  input  logic [LINE_AW-1:0] wr_line,
  input  logic               rd_valid,
  output logic               res_valid,
  output logic [1:0]         res_kind,
  output logic               res_shared
);

  logic             streaming;
  logic [CNT_W-1:0] run_cnt;
  resolved_t        res_comb;
  resolved_t        res_reg;

  mattr_stream_det #(
    .LINE_AW (LINE_AW),
    .CNT_W   (CNT_W),
    .THRESH  (THRESH)
  ) u_det (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid_i  (wr_valid),
    .wr_full_i   (wr_full),
    .wr_line_i   (wr_line),
    .rd_valid_i  (rd_valid),
    .streaming_o (streaming),
    .run_cnt_o   (run_cnt)
  );

  mattr_decode u_dec (
    .mtype_i     (acc_mtype),
    .share_i     (acc_share),
    .cpol_i      (acc_cpol),
    .smp_en_i    (smp_en),
    .streaming_i (streaming),
    .res_o       (res_comb)
  );

  mattr_out_reg u_oreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (acc_valid),
    .res_i   (res_comb),
    .valid_o (res_valid),
    .res_o   (res_reg)
  );

  assign res_kind   = res_reg.kind;
  assign res_shared = res_reg.shared;

endmodule

// File: rtl/mattr_resolver_chk.sv
module mattr_resolver_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_valid,
  input logic [1:0]       acc_mtype,
  input logic [1:0]       acc_share,
  input logic [1:0]       acc_cpol,
  input logic             smp_en,
  input logic             wr_valid,
  input logic             wr_full,
  input logic             rd_valid,
  input logic             res_valid,
  input logic [1:0]       res_kind,
  input logic             res_shared,
  input logic [CNT_W-1:0] run_cnt
);

  // R1
  strict_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_mtype != 2'd2) |=> (res_kind == 2'd0 && !res_shared));

  // R6
  run_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid || (wr_valid && !wr_full)) |=> (run_cnt == '0));

  // R7
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_full && !rd_valid) |=> (run_cnt != '0));

  // R9
  shared_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_mtype == 2'd2 && acc_share != 2'd0 && acc_cpol[1])
      |=> (res_shared && res_kind == (smp_en ? 2'd2 : 2'd1)));

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> res_valid);

  // R10
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> (!res_valid && $stable(res_kind) && $stable(res_shared)));

endmodule

bind mattr_resolver mattr_resolver_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_valid  (acc_valid),
  .acc_mtype  (acc_mtype),
  .acc_share  (acc_share),
  .acc_cpol   (acc_cpol),
  .smp_en     (smp_en),
  .wr_valid   (wr_valid),
  .wr_full    (wr_full),
  .rd_valid   (rd_valid),
  .res_valid  (res_valid),
  .res_kind   (res_kind),
  .res_shared (res_shared),
  .run_cnt    (run_cnt)
);

// File: tb/sim_mattr_resolver.sv
`timescale 1ns/1ps
module sim_mattr_resolver;

  localparam int LINE_AW = 26;

  logic               clk;
  logic               rst_n;
  logic               acc_valid;
  logic [1:0]         acc_mtype;
  logic [1:0]         acc_share;
  logic [1:0]         acc_cpol;
  logic               smp_en;
  logic               wr_valid;
  logic               wr_full;
  logic [LINE_AW-1:0] wr_line;
  logic               rd_valid;
  logic               res_valid;
  logic [1:0]         res_kind;
  logic               res_shared;

  int n_chk;
  int n_fail;
  bit done;

  mattr_resolver #(.LINE_AW(LINE_AW)) u0 (
    .clk (clk), .rst_n (rst_n), .acc_valid (acc_valid), .acc_mtype (acc_mtype),
    .acc_share (acc_share), .acc_cpol (acc_cpol), .smp_en (smp_en),
    .wr_valid (wr_valid), .wr_full (wr_full), .wr_line (wr_line),
    .rd_valid (rd_valid), .res_valid (res_valid), .res_kind (res_kind),
    .res_shared (res_shared)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic access(input string req, input logic [1:0] mt, input logic [1:0] sh,
                        input logic [1:0] cp, input logic smp,
                        input int exp_kind, input int exp_sh);
    @(negedge clk);
    acc_valid = 1'b1; acc_mtype = mt; acc_share = sh; acc_cpol = cp; smp_en = smp;
    @(negedge clk);
    acc_valid = 1'b0;
    check(req, int'(res_valid), 1);
    check(req, int'(res_kind), exp_kind);
    check(req, int'(res_shared), exp_sh);
  endtask

  task automatic store(input logic full, input int line);
    @(negedge clk);
    wr_valid = 1'b1; wr_full = full; wr_line = LINE_AW'(line);
    @(negedge clk);
    wr_valid = 1'b0; wr_full = 1'b0;
  endtask

  task automatic load();
    @(negedge clk);
    rd_valid = 1'b1;
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  task automatic run(input int first, input int n);
    for (int i = 0; i < n; i++) store(1'b1, first + i);
  endtask

  task automatic t_reset();
    check("R10 reset valid", int'(res_valid), 0);
    check("R10 reset kind", int'(res_kind), 0);
    check("R10 reset shared", int'(res_shared), 0);
  endtask

  task automatic t_strict();
    access("R1 strong", 2'd0, 2'd0, 2'd2, 1'b1, 0, 0);
    access("R1 device", 2'd1, 2'd1, 2'd3, 1'b1, 0, 0);
    access("R1 type3", 2'd3, 2'd2, 2'd0, 1'b0, 0, 0);
  endtask

  task automatic t_nonshared();
    access("R2 nc", 2'd2, 2'd0, 2'd0, 1'b0, 1, 0);
    access("R2 wt", 2'd2, 2'd0, 2'd1, 1'b1, 1, 0);
    access("R3 wb-na", 2'd2, 2'd0, 2'd3, 1'b0, 2, 0);
    access("R4 wb-wa idle", 2'd2, 2'd0, 2'd2, 1'b0, 2, 0);
  endtask

  task automatic t_stream();
    run(100, 3);
    access("R5 three lines", 2'd2, 2'd0, 2'd2, 1'b0, 2, 0);
    store(1'b1, 103);
    access("R5 four lines", 2'd2, 2'd0, 2'd2, 1'b0, 3, 0);
    access("R4 wb-na during run", 2'd2, 2'd0, 2'd3, 1'b0, 2, 0);
    store(1'b1, 500);
    run(501, 2);
    access("R5 restart at jump", 2'd2, 2'd0, 2'd2, 1'b0, 2, 0);
    store(1'b1, 503);
    access("R5 restart reaches four", 2'd2, 2'd0, 2'd2, 1'b0, 3, 0);
  endtask

  task automatic t_reset_run();
    store(1'b0, 504);
    access("R6 partial write", 2'd2, 2'd0, 2'd2, 1'b0, 2, 0);
    run(600, 4);
    access("R6 run before read", 2'd2, 2'd0, 2'd2, 1'b0, 3, 0);
    load();
    access("R6 read", 2'd2, 2'd0, 2'd2, 1'b0, 2, 0);
    store(1'b1, 700);
    access("R6 one line after read", 2'd2, 2'd0, 2'd2, 1'b0, 2, 0);
  endtask

  task automatic t_saturate();
    run(800, 12);
    access("R7 saturate", 2'd2, 2'd0, 2'd2, 1'b0, 3, 0);
  endtask

  task automatic t_shared();
    load();
    access("R8 inner nc", 2'd2, 2'd1, 2'd0, 1'b1, 1, 1);
    access("R8 outer wt", 2'd2, 2'd2, 2'd1, 1'b1, 1, 1);
    access("R9 inner wb smp0", 2'd2, 2'd1, 2'd2, 1'b0, 1, 1);
    access("R9 outer wb-na smp0", 2'd2, 2'd3, 2'd3, 1'b0, 1, 1);
    access("R9 inner wb-na smp1", 2'd2, 2'd1, 2'd3, 1'b1, 2, 1);
    run(900, 5);
    access("R9 outer wb smp1 run", 2'd2, 2'd2, 2'd2, 1'b1, 2, 1);
  endtask

  task automatic t_hold();
    access("R10 set", 2'd2, 2'd1, 2'd2, 1'b1, 2, 1);
    @(negedge clk);
    check("R10 valid drop", int'(res_valid), 0);
    check("R10 kind hold", int'(res_kind), 2);
    check("R10 shared hold", int'(res_shared), 1);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; acc_valid = 1'b0; acc_mtype = 2'd0; acc_share = 2'd0;
    acc_cpol = 2'd0; smp_en = 1'b0; wr_valid = 1'b0; wr_full = 1'b0;
    wr_line = '0; rd_valid = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_strict();
    t_nonshared();
    t_stream();
    t_reset_run();
    t_saturate();
    t_shared();
    t_hold();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule